// File: doc/BRIEF.md
# Root Clock Generator with Atomic Source and Divider Commit

This block produces a root clock from one of several free-running input clocks, divided by a ratio that moves in half steps. Software programs a pending copy of the configuration through a small register port. That copy holds which input to use and the divider code. Nothing reaches the clock path until software sets a commit bit. The commit then stops the running input, loads the new input choice and the new divider together, and starts the new input. The output therefore never runs with a mix of old and new settings.

The commit bit clears itself once the new clock is running, so software polls it to detect completion. Two further status bits are available. One shows that the pending copy differs from what is in effect. The other shows that the output is stopped. Input switching uses a break-before-make handshake. Each input's enable is synchronised inside that input's own domain and changes only while that input is low.

Top module: `rcg_root`

## Requirements
- R1: Register address 0 (reg_addr=0) is the configuration word. Its divider code sits in bits [DIV_LSB +: DIV_W], bits 4:0 by default. Its input select sits in bits [SRC_LSB +: SRC_W], bits 9:8 by default. Reads return the last accepted write. Read data appears on reg_rdata one clock after reg_addr is presented.
- R2: With a committed divider code D, the output frequency is 2*f_in/(D+1), where f_in is the frequency of the selected input. Code 1 divides by 1, code 2 by 1.5, code 3 by 2.
- R3: Divider code 0 behaves as code 1. The all-ones code behaves as all-ones minus one, which is the largest usable code.
- R4: Writing 1 to bit 0 of the command word (reg_addr=1) starts a commit, and bit 0 then reads 1. It reads 0 again once the new setting is in effect. Writing 0 to bit 0 changes nothing.
- R5: A commit completes within 16 periods of the slowest input clock. With the default bench clocks this is 24 register-clock cycles.
- R6: Command bit 4 reads 1 while the pending configuration differs from the one in effect. It reads 0 after a commit completes.
- R7: Input select and divider change only while every input is disabled. At most one input is enabled at any time.
- R8: Command bit 31 reads 1 whenever no input drives the output. This is the case partway through every commit, and it stays so after committing a select value of NSRC or above.
- R9: A configuration write arriving while a commit is in progress is dropped.
- R10: After reset the configuration reads select RST_SRC with divider code RST_DIV (0x001 by default). The command word reads 0, and the output runs at that setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of every input clock |
| src_clk | input | NSRC | Candidate input clocks |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 1 | 0 selects configuration, 1 selects command |
| reg_wdata | input | CFG_W | Write data |
| reg_rdata | output | 32 | Registered read data of the addressed word |
| clk_out | output | 1 | Root clock output |

## Verification
The divider is tried on three inputs of unrelated periods with codes giving even, odd and large half-step ratios, plus the two clamped codes. Output edges are counted across a window of 5*(D+1) input periods, and exactly ten are expected. That count separates a whole-step divider from a half-step one, and it also separates an input that was switched from one that was not. Poll traces during each commit show the stopped phase and the completion time. A late configuration write, a commit-bit write of 0 and an out-of-range select each distinguish dropped or ignored stimulus from stimulus that took effect.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int unsigned CMD_UPD_BIT   = 0;
  localparam int unsigned CMD_DIRTY_BIT = 4;
  localparam int unsigned CMD_OFF_BIT   = 31;
  localparam int unsigned RD_W          = 32;

  typedef enum logic [1:0] {
    CM_IDLE,
    CM_STOP,
    CM_LOAD,
    CM_START
  } commit_e;
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int NSRC    = 3,
  parameter int SRC_W   = 2,
  parameter int DIV_W   = 5,
  parameter int SRC_LSB = 8,
  parameter int DIV_LSB = 0,
  parameter int CFG_W   = 10,
  parameter int RST_SRC = 0,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  input  logic [NSRC-1:0]  en_raw,
  output logic [NSRC-1:0]  req_sel,
  output logic [SRC_W-1:0] live_src,
  output logic [DIV_W-1:0] live_div,
  output logic [CFG_W-1:0] shadow,
  output logic             busy,
  output logic             dirty
);
  localparam logic [CFG_W-1:0] SH_RST  = (CFG_W'(RST_SRC) << SRC_LSB) | (CFG_W'(RST_DIV) << DIV_LSB);
  localparam logic [NSRC-1:0]  SEL_RST = NSRC'(1) << RST_SRC;

  commit_e             state;
  logic [NSRC-1:0]     ack_s1, ack_q, sel_dec;
  logic [SRC_W-1:0]    sh_src;
  logic [DIV_W-1:0]    sh_div;
  logic                root_off;
  logic [RD_W-1:0]     cmd_word, cfg_word;

  assign sh_src   = shadow[SRC_LSB +: SRC_W];
  assign sh_div   = shadow[DIV_LSB +: DIV_W];
  assign busy     = (state != CM_IDLE);
  assign dirty    = (sh_src != live_src) || (sh_div != live_div);
  assign root_off = ~|ack_q;

  // one-hot request decoded from the loaded select; out-of-range gives none
  always_comb begin
    for (int i = 0; i < NSRC; i++) sel_dec[i] = (live_src == SRC_W'(i));
  end

  // enables come from other clock domains: two-flop synchroniser
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_s1 <= SEL_RST;
      ack_q  <= SEL_RST;
    end else begin
      ack_s1 <= en_raw;
      ack_q  <= ack_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CM_IDLE;
      shadow   <= SH_RST;
      live_src <= SRC_W'(RST_SRC);
      live_div <= DIV_W'(RST_DIV);
      req_sel  <= SEL_RST;
    end else begin
      case (state)
        CM_IDLE: begin
          if (reg_wr && reg_addr && reg_wdata[CMD_UPD_BIT]) begin
            req_sel <= '0;
            state   <= CM_STOP;
          end else if (reg_wr && !reg_addr) begin
            shadow <= reg_wdata;
          end
        end
        CM_STOP: begin
          if (ack_q == '0) begin
            live_src <= sh_src;
            live_div <= sh_div;
            state    <= CM_LOAD;
          end
        end
        CM_LOAD: begin
          req_sel <= sel_dec;
          state   <= CM_START;
        end
        default: begin
          if (ack_q == req_sel) state <= CM_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    cmd_word                = '0;
    cmd_word[CMD_UPD_BIT]   = busy;
    cmd_word[CMD_DIRTY_BIT] = dirty;
    cmd_word[CMD_OFF_BIT]   = root_off;
    cfg_word                = '0;
    cfg_word[CFG_W-1:0]     = shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_addr ? cmd_word : cfg_word;
  end
endmodule

// File: rtl/rcg_clk_switch.sv
module rcg_clk_switch #(
  parameter int NSRC    = 3,
  parameter int RST_SRC = 0
) (
  input  logic            rst,
  input  logic [NSRC-1:0] src_clk,
  input  logic [NSRC-1:0] req_sel,
  output logic [NSRC-1:0] en_out,
  output logic            mclk
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic s1, s2, en_n, others;
    assign others = |(en_out & ~(NSRC'(1) << i));

    // request synchronised in this input's domain, blocked while another runs
    always_ff @(posedge src_clk[i]) begin
      if (rst) begin
        s1 <= (i == RST_SRC);
        s2 <= (i == RST_SRC);
      end else begin
        s1 <= req_sel[i] & ~others;
        s2 <= s1;
      end
    end

    // enable moves only while this input is low
    always_ff @(negedge src_clk[i]) begin
      if (rst) en_n <= (i == RST_SRC);
      else     en_n <= s2;
    end

    assign en_out[i] = en_n;
    assign gated[i]  = src_clk[i] & en_n;
  end

  assign mclk = |gated;
endmodule

// File: rtl/rcg_halfdiv.sv
module rcg_halfdiv #(
  parameter int DIV_W = 5
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_raw,
  output logic             clk_out
);
  localparam int HW = DIV_W + 2;
  localparam logic [DIV_W-1:0] DMAX = {{(DIV_W-1){1'b1}}, 1'b0};

  logic [DIV_W-1:0] d_eff, cnt, cnt_nxt, div_q;
  logic [HW-1:0]    n_half, h_cnt, h_lo, h_hi, m_lo, m_hi;
  logic             ph_lo, ph_hi;

  always_comb begin
    d_eff = div_raw;
    if (div_raw == '0)      d_eff = DIV_W'(1);
    else if (div_raw == '1) d_eff = DMAX;
    n_half = HW'(d_eff) + HW'(1);     // output period in input half-cycles
    h_cnt  = n_half >> 1;             // half-cycles spent high
    cnt_nxt = (div_q != div_raw || cnt >= d_eff) ? '0 : cnt + DIV_W'(1);
    h_lo = HW'({cnt_nxt, 1'b1});
    h_hi = HW'({cnt_nxt, 1'b0});
    m_lo = (h_lo >= n_half) ? h_lo - n_half : h_lo;
    m_hi = (h_hi >= n_half) ? h_hi - n_half : h_hi;
  end

  // low-phase level: loaded at rising edge, used while mclk is low
  always_ff @(posedge mclk) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= div_raw;
      ph_lo <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      div_q <= div_raw;
      ph_lo <= (m_lo < h_cnt);
    end
  end

  // high-phase level: loaded at falling edge, used while mclk is high
  always_ff @(negedge mclk) begin
    if (rst) ph_hi <= 1'b0;
    else     ph_hi <= (m_hi < h_cnt);
  end

  assign clk_out = (mclk & ph_hi) | (~mclk & ph_lo);
endmodule

// File: rtl/rcg_root.sv
module rcg_root
  import rcg_pkg::*;
#(
  parameter int NSRC    = 3,
  parameter int SRC_W   = 2,
  parameter int DIV_W   = 5,
  parameter int SRC_LSB = 8,
  parameter int DIV_LSB = 0,
  parameter int RST_SRC = 0,
  parameter int RST_DIV = 1,
  localparam int CFG_W  = (SRC_LSB + SRC_W > DIV_LSB + DIV_W) ? SRC_LSB + SRC_W : DIV_LSB + DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_clk,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  output logic             clk_out
);
  logic [NSRC-1:0]  en_raw, req_sel;
  logic [SRC_W-1:0] live_src;
  logic [DIV_W-1:0] live_div;
  logic [CFG_W-1:0] shadow;
  logic             busy, dirty, mclk;

  rcg_regs #(
    .NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .SRC_LSB(SRC_LSB), .DIV_LSB(DIV_LSB),
    .CFG_W(CFG_W), .RST_SRC(RST_SRC), .RST_DIV(RST_DIV)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .en_raw(en_raw), .req_sel(req_sel), .live_src(live_src),
    .live_div(live_div), .shadow(shadow), .busy(busy), .dirty(dirty)
  );

  rcg_clk_switch #(.NSRC(NSRC), .RST_SRC(RST_SRC)) u_sw (
    .rst(rst), .src_clk(src_clk), .req_sel(req_sel), .en_out(en_raw), .mclk(mclk)
  );

  rcg_halfdiv #(.DIV_W(DIV_W)) u_div (
    .mclk(mclk), .rst(rst), .div_raw(live_div), .clk_out(clk_out)
  );
endmodule

// File: rtl/rcg_root_chk.sv
module rcg_root_chk #(
  parameter int NSRC  = 3,
  parameter int SRC_W = 2,
  parameter int DIV_W = 5,
  parameter int CFG_W = 10,
  parameter int LIMIT = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             upd_bit,
  input logic [NSRC-1:0]  en_raw,
  input logic [SRC_W-1:0] live_src,
  input logic [DIV_W-1:0] live_div,
  input logic [CFG_W-1:0] shadow,
  input logic             busy,
  input logic             dirty
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)                busy_cnt <= '0;
    else if (busy && busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 8'd1;
    else if (!busy)         busy_cnt <= '0;
  end

  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr && reg_addr && upd_bit) |=> busy);

  p_commit_bound_r5: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= 8'(LIMIT));

  p_dirty_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !dirty);

  p_no_mixed_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(live_src) || !$stable(live_div)) |-> (en_raw == '0));

  p_one_source_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_raw));

  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && !reg_addr) |=> $stable(shadow));
endmodule

bind rcg_root rcg_root_chk #(
  .NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .CFG_W(CFG_W), .LIMIT(24)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .upd_bit(reg_wdata[0]),
  .en_raw(en_raw), .live_src(live_src), .live_div(live_div), .shadow(shadow),
  .busy(busy), .dirty(dirty)
);

// File: tb/sim_rcg_root.sv
`timescale 1ns/1ps
module sim_rcg_root;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src_clk = 3'b000;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [9:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_out;
  int          checks = 0;
  int          errors = 0;
  int          edge_cnt = 0;

  always #10 clk = ~clk;          // 50 MHz register clock
  always #4  src_clk[0] = ~src_clk[0];
  always #6  src_clk[1] = ~src_clk[1];
  always #15 src_clk[2] = ~src_clk[2];

  rcg_root u0 (
    .clk(clk), .rst(rst), .src_clk(src_clk), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
  );

  always @(posedge clk_out) edge_cnt++;

  // {select[1:0], divider code[4:0], expected half-cycle period N[5:0]}
  localparam logic [12:0] VEC [8] = '{
    {2'd1, 5'd1,  6'd2},
    {2'd0, 5'd2,  6'd3},
    {2'd2, 5'd3,  6'd4},
    {2'd1, 5'd6,  6'd7},
    {2'd0, 5'd9,  6'd10},
    {2'd2, 5'd4,  6'd5},
    {2'd0, 5'd0,  6'd2},
    {2'd1, 5'd31, 6'd31}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [9:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_src(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      case (s)
        0:       @(posedge src_clk[0]);
        1:       @(posedge src_clk[1]);
        default: @(posedge src_clk[2]);
      endcase
    end
    #1;
  endtask

  task automatic measure(input int s, input int n, output int edges);
    int e0;
    wait_src(s, 3);
    e0 = edge_cnt;
    wait_src(s, 5 * n);
    edges = edge_cnt - e0;
    @(negedge clk);
  endtask

  task automatic commit(output int cycles, output bit off_seen);
    logic [31:0] d;
    wr(1'b1, 10'h001);
    cycles = 0; off_seen = 0;
    do begin
      rd(1'b1, d);
      cycles++;
      if (d[31]) off_seen = 1;
    end while (d[0] && cycles < 100);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc, edges;
    bit offs;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    rd(1'b0, d); check(d == 32'h001, "R10 cfg after reset", d, 32'h001);
    rd(1'b1, d); check(d == 32'h0,   "R10 cmd after reset", d, 0);
    measure(0, 2, edges); check(edges >= 9 && edges <= 11, "R10 reset output rate", edges, 10);

    // R4 writing 0 to commit bit does nothing; R6 dirty set
    wr(1'b0, 10'h003);
    wr(1'b1, 10'h000);
    rd(1'b1, d); check(d == 32'h10, "R4 zero write no commit, R6 dirty", d, 32'h10);
    measure(0, 2, edges); check(edges >= 9 && edges <= 11, "R4 rate unchanged", edges, 10);

    // table walk: R1 R2 R3 R5 R6 R8
    for (int v = 0; v < 8; v++) begin
      logic [1:0] s;
      logic [4:0] raw;
      logic [5:0] n;
      logic [9:0] w;
      {s, raw, n} = VEC[v];
      w = {s, 3'b000, raw};
      wr(1'b0, w);
      rd(1'b1, d); check(d == 32'h10, "R6 dirty before commit", d, 32'h10);
      commit(cyc, offs);
      check(cyc > 1, "R4 update reads 1 while committing", cyc, 2);
      check(cyc <= 25, "R5 commit bound", cyc, 25);
      check(offs, "R8 root off seen during commit", offs, 1);
      rd(1'b1, d); check(d == 32'h0, "R6 R8 cmd after commit", d, 0);
      rd(1'b0, d); check(d == 32'(w), "R1 cfg readback", d, w);
      measure(int'(s), int'(n), edges);
      check(edges >= 9 && edges <= 11, (raw == 0 || raw == 31) ? "R3 clamped code rate" : "R2 half-step rate", edges, 10);
    end

    // R9 configuration write during commit dropped
    wr(1'b0, 10'h001);
    wr(1'b1, 10'h001);
    wr(1'b0, 10'h207);
    cyc = 0;
    do begin rd(1'b1, d); cyc++; end while (d[0] && cyc < 100);
    rd(1'b0, d); check(d == 32'h001, "R9 late cfg write dropped", d, 32'h001);
    rd(1'b1, d); check(d == 32'h0, "R9 no dirty after drop", d, 0);
    measure(0, 2, edges); check(edges >= 9 && edges <= 11, "R9 rate of first setting", edges, 10);

    // R8 out-of-range select stops the output
    wr(1'b0, 10'h301);
    commit(cyc, offs);
    check(cyc <= 25, "R5 commit bound invalid select", cyc, 25);
    rd(1'b1, d); check(d == 32'h8000_0000, "R8 root off after invalid select", d, 32'h8000_0000);
    measure(0, 12, edges); check(edges == 0, "R8 no output edges", edges, 0);

    // recover to input 1 at ratio 1.5 (R2, R7)
    wr(1'b0, 10'h102);
    commit(cyc, offs);
    rd(1'b1, d); check(d == 32'h0, "R7 restart after stop", d, 0);
    measure(1, 3, edges); check(edges >= 9 && edges <= 11, "R2 rate after restart", edges, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule